// File: doc/BRIEF.md
# Programmable FIFO Threshold Flag Generator

This block turns a pair of FIFO position counters into four status flags: full, empty, almost-full and almost-empty. It receives the 16-bit write and read counters produced by the address-counter logic of a FIFO built from one or more cascaded RAM blocks. It subtracts them over the range of counter bits that the current geometry uses, and compares the coarse part of that fill level with two 8-bit programmable thresholds.

The thresholds have a granularity of 256 counter units. A threshold value T lines up with bits 15:8 of the fill difference. A cascade-depth select sets how many counter bits are active and how many threshold bits take part in the comparison. Bits outside that range are forced to zero on both sides. All four flags are registered, so they follow a pointer change by exactly one clock.

The active counter field is the low A = 12 + k bits, where k is the effective cascade code. Its top bit, A-1, acts as the wrap bit. The usable capacity is therefore 2^(A-1) counter units, and the fill level d = (write - read) mod 2^A lies between 0 and that capacity.

Top module: `fifo_flag_gen`

## Requirements
- R1: While rst_ni is low, the flags read empty_o=1, aempty_o=1, full_o=0, afull_o=0.
- R2: The cascade code casc_i selects k: 0 gives k=0 (single block), 1 gives k=1 (2 blocks), 2 gives k=2 (4 blocks), 3 gives k=3 (8 blocks) and 4 gives k=4 (16 blocks). Codes 5 to 7 behave as code 4. The active counter width is A = 12 + k.
- R3: empty_o is 1 exactly when the write and read counters agree on bits A-1:0.
- R4: full_o is 1 exactly when d = 2^(A-1), that is, when the counters agree on bits A-2:0 and differ in bit A-1.
- R5: afull_o is 1 exactly when d[15:8] >= (af_thr_i with bits 7:4+k cleared).
- R6: aempty_o is 1 exactly when d[15:8] <= (ae_thr_i with bits 7:4+k cleared).
- R7: Threshold bits 7:4+k have no effect on any flag.
- R8: Counter bits 15:A of either counter have no effect on any flag.
- R9: Each flag reflects the inputs sampled at the previous rising clock edge. A change on any input is visible on the flags only after the next rising edge.
- R10: full_o and empty_o are never 1 together, and empty_o=1 implies aempty_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_cnt_i | input | 16 | Write position counter |
| rd_cnt_i | input | 16 | Read position counter |
| af_thr_i | input | 8 | Almost-full threshold, in units of 256 |
| ae_thr_i | input | 8 | Almost-empty threshold, in units of 256 |
| casc_i | input | 3 | Cascade depth code |
| full_o | output | 1 | FIFO holds 2^(A-1) entries |
| empty_o | output | 1 | FIFO holds no entries |
| afull_o | output | 1 | Fill level at or above the almost-full threshold |
| aempty_o | output | 1 | Fill level at or below the almost-empty threshold |

## Verification
The hardest state to reach is full at the deepest geometry. There, d must equal exactly 0x8000, so the wrap bit is bit 15 and no counter bits are inactive. Every other configuration has a lower wrap bit and leaves spare upper bits.

The bench does not count a FIFO up to that point. It builds each pointer pair arithmetically: it picks a random read position, adds the target fill, then scrambles the inactive upper bits of each counter and the ignored threshold bits on their own. This lets a single sweep walk every coarse fill step from empty to full for all eight cascade codes.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
  typedef struct packed {
    logic full;
    logic empty;
    logic afull;
    logic aempty;
  } flags_t;

  localparam flags_t FLAGS_RST = '{full: 1'b0, empty: 1'b1, afull: 1'b0, aempty: 1'b1};
endpackage

// File: rtl/fifo_flag_mask.sv
module fifo_flag_mask #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned THR_W  = 8,
  parameter int unsigned BASE_W = 4,
  parameter int unsigned MODE_W = 3
) (
  input  logic [MODE_W-1:0] casc_i,
  output logic [CNT_W-1:0]  cnt_mask_o,
  output logic [CNT_W-1:0]  wrap_o,
  output logic [THR_W-1:0]  thr_mask_o
);
  localparam int unsigned FRAC_W   = CNT_W - THR_W;
  localparam int unsigned MAX_CASC = THR_W - BASE_W;

  logic [MODE_W-1:0] casc_eff;
  logic [31:0]       act_w;
  logic [31:0]       thr_w;

  // out-of-range codes saturate to the deepest cascade
  always_comb begin
    casc_eff = (32'(casc_i) > MAX_CASC) ? MODE_W'(MAX_CASC) : casc_i;
    act_w    = FRAC_W + BASE_W + 32'(casc_eff);
    thr_w    = BASE_W + 32'(casc_eff);
  end

  for (genvar i = 0; i < CNT_W; i++) begin : g_cnt
    assign cnt_mask_o[i] = (32'(i) < act_w);
    assign wrap_o[i]     = ((32'(i) + 32'd1) == act_w);
  end

  for (genvar j = 0; j < THR_W; j++) begin : g_thr
    assign thr_mask_o[j] = (32'(j) < thr_w);
  end
endmodule

// File: rtl/fifo_flag_diff.sv
module fifo_flag_diff #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned THR_W = 8
) (
  input  logic [CNT_W-1:0] wr_i,
  input  logic [CNT_W-1:0] rd_i,
  input  logic [CNT_W-1:0] cnt_mask_i,
  input  logic [CNT_W-1:0] wrap_i,
  output logic [THR_W-1:0] diff_hi_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [CNT_W-1:0] diff;
  logic [CNT_W-1:0] xdiff;

  always_comb begin
    diff      = (wr_i - rd_i) & cnt_mask_i;
    xdiff     = (wr_i ^ rd_i) & cnt_mask_i;
    diff_hi_o = diff[CNT_W-1 -: THR_W];
    empty_o   = (xdiff == '0);
    // low bits agree, wrap bit differs
    full_o    = (xdiff == wrap_i);
  end
endmodule

// File: rtl/fifo_flag_cmp.sv
module fifo_flag_cmp #(
  parameter int unsigned THR_W = 8
) (
  input  logic [THR_W-1:0] diff_hi_i,
  input  logic [THR_W-1:0] af_thr_i,
  input  logic [THR_W-1:0] ae_thr_i,
  input  logic [THR_W-1:0] thr_mask_i,
  output logic             afull_o,
  output logic             aempty_o
);
  logic [THR_W-1:0] af_eff;
  logic [THR_W-1:0] ae_eff;

  always_comb begin
    af_eff   = af_thr_i & thr_mask_i;
    ae_eff   = ae_thr_i & thr_mask_i;
    afull_o  = (diff_hi_i >= af_eff);
    aempty_o = (diff_hi_i <= ae_eff);
  end
endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen
  import fifo_flag_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned THR_W  = 8,
  parameter int unsigned BASE_W = 4,
  parameter int unsigned MODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  wr_cnt_i,
  input  logic [CNT_W-1:0]  rd_cnt_i,
  input  logic [THR_W-1:0]  af_thr_i,
  input  logic [THR_W-1:0]  ae_thr_i,
  input  logic [MODE_W-1:0] casc_i,
  output logic              full_o,
  output logic              empty_o,
  output logic              afull_o,
  output logic              aempty_o
);
  logic [CNT_W-1:0] cnt_mask;
  logic [CNT_W-1:0] wrap;
  logic [THR_W-1:0] thr_mask;
  logic [THR_W-1:0] diff_hi;
  flags_t           flags_d;
  flags_t           flags_q;

  fifo_flag_mask #(
    .CNT_W(CNT_W), .THR_W(THR_W), .BASE_W(BASE_W), .MODE_W(MODE_W)
  ) mask_i (
    .casc_i    (casc_i),
    .cnt_mask_o(cnt_mask),
    .wrap_o    (wrap),
    .thr_mask_o(thr_mask)
  );

  fifo_flag_diff #(.CNT_W(CNT_W), .THR_W(THR_W)) diff_i (
    .wr_i      (wr_cnt_i),
    .rd_i      (rd_cnt_i),
    .cnt_mask_i(cnt_mask),
    .wrap_i    (wrap),
    .diff_hi_o (diff_hi),
    .empty_o   (flags_d.empty),
    .full_o    (flags_d.full)
  );

  fifo_flag_cmp #(.THR_W(THR_W)) cmp_i (
    .diff_hi_i (diff_hi),
    .af_thr_i  (af_thr_i),
    .ae_thr_i  (ae_thr_i),
    .thr_mask_i(thr_mask),
    .afull_o   (flags_d.afull),
    .aempty_o  (flags_d.aempty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= FLAGS_RST;
    else         flags_q <= flags_d;
  end

  assign full_o   = flags_q.full;
  assign empty_o  = flags_q.empty;
  assign afull_o  = flags_q.afull;
  assign aempty_o = flags_q.aempty;
endmodule

// File: rtl/fifo_flag_gen_chk.sv
module fifo_flag_gen_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned THR_W  = 8,
  parameter int unsigned BASE_W = 4,
  parameter int unsigned MODE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  wr_cnt_i,
  input logic [CNT_W-1:0]  rd_cnt_i,
  input logic [THR_W-1:0]  af_thr_i,
  input logic [THR_W-1:0]  ae_thr_i,
  input logic [MODE_W-1:0] casc_i,
  input logic              full_o,
  input logic              empty_o,
  input logic              afull_o,
  input logic              aempty_o
);
  localparam int unsigned MAX_CASC = THR_W - BASE_W;
  localparam logic [CNT_W-1:0] TOP = {1'b1, {(CNT_W-1){1'b0}}};

  logic [31:0]      k_eff;
  logic [31:0]      act_w;
  logic [CNT_W-1:0] xsh;
  logic             valid_q;

  always_comb begin
    k_eff = (32'(casc_i) > MAX_CASC) ? 32'(MAX_CASC) : 32'(casc_i);
    act_w = CNT_W - THR_W + BASE_W + k_eff;
    // push inactive bits out the top so only the active field remains
    xsh   = (wr_cnt_i ^ rd_cnt_i) << (CNT_W - act_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= 1'b1;
  end

  assert_empty_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (empty_o == $past(xsh == '0)));

  assert_full_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (full_o == $past(xsh == TOP)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && $stable(wr_cnt_i) && $stable(rd_cnt_i) && $stable(af_thr_i) &&
     $stable(ae_thr_i) && $stable(casc_i))
    |=> $stable({full_o, empty_o, afull_o, aempty_o}));

  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  assert_empty_aempty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> aempty_o);
endmodule

bind fifo_flag_gen fifo_flag_gen_chk #(
  .CNT_W(CNT_W), .THR_W(THR_W), .BASE_W(BASE_W), .MODE_W(MODE_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_cnt_i(wr_cnt_i),
  .rd_cnt_i(rd_cnt_i),
  .af_thr_i(af_thr_i),
  .ae_thr_i(ae_thr_i),
  .casc_i  (casc_i),
  .full_o  (full_o),
  .empty_o (empty_o),
  .afull_o (afull_o),
  .aempty_o(aempty_o)
);

// File: tb/fifo_flag_gen_tb.sv
`timescale 1ns/1ps
module fifo_flag_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wr = '0;
  logic [15:0] rd = '0;
  logic [7:0]  af = '0;
  logic [7:0]  ae = '0;
  logic [2:0]  casc = '0;
  logic        full, empty, afull, aempty;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] rs = 32'h1357_9bdf;

  always #2.5 clk = ~clk;

  fifo_flag_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_cnt_i(wr), .rd_cnt_i(rd),
    .af_thr_i(af), .ae_thr_i(ae), .casc_i(casc),
    .full_o(full), .empty_o(empty), .afull_o(afull), .aempty_o(aempty)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic chk(input logic got, input logic exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b exp %0b", what, got, exp);
    end
  endtask

  // apply one vector, wait one edge, compare with arithmetic model
  task automatic run_vec(input logic [2:0] m, input logic [15:0] w, input logic [15:0] r,
                         input logic [7:0] a, input logic [7:0] e, input string tag);
    int k, aw;
    logic [31:0] msk, dm, hi, am, em;
    casc = m; wr = w; rd = r; af = a; ae = e;
    @(negedge clk);
    k  = (m > 3'd4) ? 4 : int'(m);
    aw = 12 + k;
    msk = (32'd1 << aw) - 32'd1;
    dm = ({16'd0, w} - {16'd0, r}) & msk;
    hi = dm >> 8;
    am = {24'd0, a} & ((32'd1 << (4 + k)) - 32'd1);
    em = {24'd0, e} & ((32'd1 << (4 + k)) - 32'd1);
    chk(empty,  dm == 32'd0,                 {tag, " R3 empty"});
    chk(full,   dm == (32'd1 << (aw - 1)),   {tag, " R4 full"});
    chk(afull,  hi >= am,                    {tag, " R5 afull"});
    chk(aempty, hi <= em,                    {tag, " R6 aempty"});
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int tl[12];
    int offs[3];
    tl = '{0, 1, 3, 7, 15, 16, 31, 63, 127, 255, 165, 90};
    offs = '{0, 1, 255};

    // R1: reset values, with a non-empty pointer pair present
    wr = 16'h0300; rd = 16'h0000; af = 8'h01; ae = 8'h00;
    @(posedge clk); @(negedge clk);
    chk(empty,  1'b1, "R1 reset empty");
    chk(aempty, 1'b1, "R1 reset aempty");
    chk(full,   1'b0, "R1 reset full");
    chk(afull,  1'b0, "R1 reset afull");
    rst_n = 1'b1;
    run_vec(3'd0, 16'h0000, 16'h0000, 8'h02, 8'h00, "R1 post");

    // R9: change not visible before the next rising edge
    casc = 3'd0; wr = 16'h0400; rd = 16'h0000; af = 8'h02; ae = 8'h01;
    #1;
    chk(empty, 1'b1, "R9 pre-edge empty");
    chk(afull, 1'b0, "R9 pre-edge afull");
    @(negedge clk);
    chk(empty, 1'b0, "R9 post-edge empty");
    chk(afull, 1'b1, "R9 post-edge afull");

    // R7: threshold bits 7:4 ignored in single-block mode
    run_vec(3'd0, 16'h0500, 16'h0000, 8'hF5, 8'hF4, "R7");
    chk(afull,  1'b1, "R7 afull masked threshold");
    chk(aempty, 1'b0, "R7 aempty masked threshold");

    // R8: upper counter bits ignored
    run_vec(3'd0, 16'hF000, 16'h0000, 8'h01, 8'h00, "R8");
    chk(empty, 1'b1, "R8 empty with bits 15:12 set");
    run_vec(3'd2, 16'h4800, 16'h8800, 8'h01, 8'h00, "R8");
    chk(empty, 1'b1, "R8 empty with bits 15:14 differing");

    // R2: codes 5..7 act as the 16-block depth
    run_vec(3'd6, 16'h8000, 16'h0000, 8'hFF, 8'h00, "R2");
    chk(full, 1'b1, "R2 code 6 full at 0x8000");
    run_vec(3'd0, 16'h0800, 16'h0000, 8'hFF, 8'h00, "R2");
    chk(full, 1'b1, "R2 code 0 full at 0x800");

    // R10: empty implies aempty
    run_vec(3'd4, 16'h1234, 16'h1234, 8'h00, 8'h00, "R10");
    chk(aempty && !full, 1'b1, "R10 empty relation");

    // sweep: every code, coarse fill steps, scrambled ignored bits
    for (int m = 0; m < 8; m++) begin
      int k, aw, cap;
      logic [15:0] hi_cnt;
      logic [7:0]  hi_thr;
      k   = (m > 4) ? 4 : m;
      aw  = 12 + k;
      cap = 1 << (aw - 1);
      hi_cnt = 16'(~((32'd1 << aw) - 32'd1));
      hi_thr = 8'(~((32'd1 << (4 + k)) - 32'd1));
      for (int t = 0; t < 12; t++) begin
        for (int u = 0; u <= (cap >> 8); u++) begin
          for (int o = 0; o < 3; o++) begin
            int d;
            logic [15:0] r, w;
            logic [7:0]  a, e;
            d = u * 256 + offs[o];
            if (d <= cap) begin
              rs = nxt(rs);
              r = rs[15:0];
              w = r + 16'(d);
              w = w ^ (rs[31:16] & hi_cnt);
              rs = nxt(rs);
              r = r ^ (rs[15:0] & hi_cnt);
              a = 8'(tl[t]);
              e = 8'(tl[(t + 5) % 12]);
              if (u[0]) begin
                a = a | (rs[23:16] & hi_thr);
                e = e | (rs[31:24] & hi_thr);
              end
              run_vec(3'(m), w, r, a, e, "R2 R7 R8 sweep");
            end
          end
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule